// File: doc/BRIEF.md
# DMA Feed Interrupt Controller

This block is the software-facing control front of a cipher engine fed by four DMA channels: a block-receive channel, a block-transmit channel, a hash-receive channel and a public-key channel. Each channel has a start-address register, a length register and a control register. Writing the length register launches that channel's transfer at once: the block emits a one-cycle start pulse while the latched address and the new length are on its outputs.

Completion of a transfer arrives as a one-cycle done pulse per channel. The pulse latches a pending flag. Software writes ones to clear pending flags. An enable mask gates which pending flags reach the single interrupt output. The mask has no plain write path. It changes only through a write-one-to-enable register and a separate write-one-to-disable register, so two software contexts can each change their own sources without a read-modify-write race. The block also reports the FIFO full and empty levels of every channel, and it holds the selector that chooses the hash engine's input source.

Access goes over a simple 32-bit register bus. A write completes in one clock. Read data is combinational from the address.

Top module: `dfic_top`

## Requirements
- R1: A write to 0x04 sets every enable bit whose write-data bit is 1. A write to 0x08 clears every enable bit whose write-data bit is 1. Zero bits leave the mask unchanged. Reading 0x04 returns the mask. Mask and pending bit 3 belong to block-receive, bit 2 to block-transmit, bit 1 to hash-receive and bit 0 to public-key.
- R2: A done pulse on a channel sets its pending bit on the next clock edge. Reading 0x0C returns the raw pending bits. Writing ones to 0x0C clears exactly those bits, and zero bits leave the others set.
- R3: If a done pulse and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R4: Reading 0x00 returns pending AND enable. The interrupt output is high exactly when that value is non-zero.
- R5: Reading 0x10 returns the FIFO levels: bit 2k+1 is the full flag and bit 2k is the empty flag of the channel whose pending bit is k. Block-receive therefore sits at bits 7/6 and public-key at bits 1/0.
- R6: Bits 1..0 of the register at 0x14 drive the hash-source selector (0 independent, 1 cipher input, 2 cipher output). The register reads back as written.
- R7: The channel register groups are at 0x20 (block-receive), 0x30 (block-transmit), 0x40 (hash-receive) and 0x50 (public-key). In each group, +0 is the start address, +4 is the length and +8 is the control register. Address and length are 32 bits wide and read back as written.
- R8: A write to a channel's length register makes that channel's start output high for exactly the one cycle after the write edge. In that cycle the channel's address and length outputs carry the latched address and the written length.
- R9: In the three non-public-key control registers, bit 0 is flush and bit 1 is byte swap. In the public-key control register, bit 0 is flush, bit 1 is transmit, bit 2 is descending order and bit 3 is byte swap. Flush is high for one cycle after the write and then reads back as 0. Control bits outside these positions read as 0.
- R10: Reset clears all enables, pending bits, addresses, lengths, control bits and the hash-source selector. While reset is held, no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chan_done | input | 4 | Per-channel transfer-done pulse |
| fifo_full | input | 4 | Per-channel FIFO full level |
| fifo_empty | input | 4 | Per-channel FIFO empty level |
| chan_start | output | 4 | Per-channel one-cycle start pulse |
| chan_addr | output | 128 | Latched start address, 32 bits per channel, channel k at [32k+31:32k] |
| chan_len | output | 128 | Latched length, 32 bits per channel |
| chan_flush | output | 4 | Per-channel flush request pulse |
| chan_swap | output | 4 | Per-channel byte-swap enable |
| pk_transmit | output | 1 | Public-key channel transmit direction |
| pk_descend | output | 1 | Public-key channel descending order |
| hash_src | output | 2 | Hash input source selector |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted pending or enable flop is visible at the ports within one cycle. The status word at 0x00 and the interrupt line both diverge from the value predicted by the done pulses and mask writes seen so far, and the raw pending word at 0x0C shows which side went wrong. A wrong channel decode shows up differently: a start pulse, flush pulse or readback appears on a neighbouring channel the cycle after the write. That makes the per-channel start and flush vectors the fastest detectors of address-map faults. The same-cycle done-versus-clear race only shows as a missing pending bit after the clear, so the bench drives that collision directly.

// File: rtl/dfic_pkg.sv
// Package: register map constants and widths shared by the feed controller.
// Assumes a byte-addressed 8-bit register space with word-aligned registers.
package dfic_pkg;
    localparam int ADDR_W     = 8;
    localparam int CH_BASE    = 32;   // first channel group (0x20)
    localparam int CH_STRIDE  = 16;   // distance between channel groups
    localparam int OFS_ADDR   = 0;
    localparam int OFS_LEN    = 4;
    localparam int OFS_CTRL   = 8;

    localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] A_EN_SET = 8'h04;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] A_PEND   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_FIFO   = 8'h10;
    localparam logic [ADDR_W-1:0] A_FCTRL  = 8'h14;

    localparam int HSRC_W = 2;

    // Byte address of the register group for the channel whose bit index is idx
    function automatic logic [ADDR_W-1:0] group_base(input int idx, input int nch);
        return ADDR_W'(CH_BASE + (nch - 1 - idx) * CH_STRIDE);
    endfunction
endpackage

// File: rtl/dfic_irq_core.sv
// Interrupt core: enable mask with separate set/clear writes, pending flags
// cleared by writing ones, and the combined interrupt line.
// Assumes at most one of the three write strobes is active per cycle.
module dfic_irq_core #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_set_we,
    input  logic           en_clr_we,
    input  logic           pend_clr_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] done,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] active,
    output logic           irq
);
    // Enable mask: write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_set_we)
            en_q <= en_q | wbits;
        else if (en_clr_we)
            en_q <= en_q & ~wbits;
    end

    // Pending flags: a done pulse wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~(pend_clr_we ? wbits : '0)) | done;
    end

    // Masked sources and the combined request line
    assign active = pend_q & en_q;
    assign irq    = |active;

    p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_we |=> ((en_q & $past(wbits)) == $past(wbits)));
    p_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_we |=> ((en_q & $past(wbits)) == '0));
    p_done_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> ((pend_q & $past(done)) == $past(done)));
    p_pend_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_we |=> ((pend_q & $past(wbits) & ~$past(done)) == '0));
endmodule

// File: rtl/dfic_channel.sv
// One DMA feed channel register group: start address, length and the
// generic flush/byte-swap control bits. A length write launches a start
// pulse. Assumes bus_we lasts one cycle per write.
module dfic_channel #(
    parameter int                         DW       = 32,
    parameter int                         AW       = 8,
    parameter logic [AW-1:0]              BASE     = '0,
    parameter int                         SWAP_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic          start_o,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] len_o,
    output logic          flush_o,
    output logic          swap_o,
    output logic [DW-1:0] rd_data_o
);
    localparam logic [AW-1:0] R_ADDR = BASE + AW'(dfic_pkg::OFS_ADDR);
    localparam logic [AW-1:0] R_LEN  = BASE + AW'(dfic_pkg::OFS_LEN);
    localparam logic [AW-1:0] R_CTRL = BASE + AW'(dfic_pkg::OFS_CTRL);

    logic wr_addr, wr_len, wr_ctrl;
    assign wr_addr = bus_we && (bus_addr == R_ADDR);
    assign wr_len  = bus_we && (bus_addr == R_LEN);
    assign wr_ctrl = bus_we && (bus_addr == R_CTRL);

    // Start address latch
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_o <= '0;
        else if (wr_addr) addr_o <= bus_wdata;
    end

    // Length latch plus start pulse in the cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o   <= '0;
            start_o <= 1'b0;
        end else begin
            start_o <= wr_len;
            if (wr_len) len_o <= bus_wdata;
        end
    end

    // Byte-swap level and self-clearing flush request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_o  <= 1'b0;
            flush_o <= 1'b0;
        end else begin
            flush_o <= wr_ctrl && bus_wdata[0];
            if (wr_ctrl) swap_o <= bus_wdata[SWAP_BIT];
        end
    end

    // Readback of this group, zero when the address misses it
    always_comb begin
        rd_data_o = '0;
        if (bus_addr == R_ADDR)      rd_data_o = addr_o;
        else if (bus_addr == R_LEN)  rd_data_o = len_o;
        else if (bus_addr == R_CTRL) begin
            rd_data_o[0]        = flush_o;
            rd_data_o[SWAP_BIT] = swap_o;
        end
    end

    p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(wr_len));
    p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ($past(wr_ctrl) && $past(bus_wdata[0])));
    p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_len |=> $stable(len_o));
endmodule

// File: rtl/dfic_top.sv
// DMA feed interrupt controller top: decodes the register bus, instantiates
// the interrupt core and one register group per channel, and holds the
// public-key mode bits, FIFO status view and hash-source selector.
// Assumes channel bit index 0 is the public-key channel.
module dfic_top #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [dfic_pkg::ADDR_W-1:0] bus_addr,
    input  logic                        bus_we,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    input  logic [NCH-1:0]              chan_done,
    input  logic [NCH-1:0]              fifo_full,
    input  logic [NCH-1:0]              fifo_empty,
    output logic [NCH-1:0]              chan_start,
    output logic [NCH*DW-1:0]           chan_addr,
    output logic [NCH*DW-1:0]           chan_len,
    output logic [NCH-1:0]              chan_flush,
    output logic [NCH-1:0]              chan_swap,
    output logic                        pk_transmit,
    output logic                        pk_descend,
    output logic [dfic_pkg::HSRC_W-1:0] hash_src,
    output logic                        irq
);
    import dfic_pkg::*;

    localparam int            PK_IDX  = 0;
    localparam logic [ADDR_W-1:0] PK_CTRL = group_base(PK_IDX, NCH) + ADDR_W'(OFS_CTRL);

    logic [NCH-1:0] en_q, pend_q, active;
    logic [DW-1:0]  ch_rd [NCH];
    logic [1:0]     pk_mode_q;

    // Interrupt core with decoded write strobes
    dfic_irq_core #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set_we  (bus_we && bus_addr == A_EN_SET),
        .en_clr_we  (bus_we && bus_addr == A_EN_CLR),
        .pend_clr_we(bus_we && bus_addr == A_PEND),
        .wbits      (bus_wdata[NCH-1:0]),
        .done       (chan_done),
        .en_q       (en_q),
        .pend_q     (pend_q),
        .active     (active),
        .irq        (irq)
    );

    // One register group per channel; the public-key group swaps at bit 3
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int SWB = (i == PK_IDX) ? 3 : 1;
        dfic_channel #(
            .DW      (DW),
            .AW      (ADDR_W),
            .BASE    (group_base(i, NCH)),
            .SWAP_BIT(SWB)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_addr (bus_addr),
            .bus_we   (bus_we),
            .bus_wdata(bus_wdata),
            .start_o  (chan_start[i]),
            .addr_o   (chan_addr[i*DW +: DW]),
            .len_o    (chan_len[i*DW +: DW]),
            .flush_o  (chan_flush[i]),
            .swap_o   (chan_swap[i]),
            .rd_data_o(ch_rd[i])
        );
    end

    // Public-key transmit and descending-order bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            pk_mode_q <= '0;
        else if (bus_we && bus_addr == PK_CTRL)
            pk_mode_q <= bus_wdata[2:1];
    end
    assign pk_transmit = pk_mode_q[0];
    assign pk_descend  = pk_mode_q[1];

    // Hash input source selector
    always_ff @(posedge clk) begin
        if (!rst_n)
            hash_src <= '0;
        else if (bus_we && bus_addr == A_FCTRL)
            hash_src <= bus_wdata[HSRC_W-1:0];
    end

    // Read multiplexer over global registers and channel groups
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS: bus_rdata[NCH-1:0] = active;
            A_EN_SET: bus_rdata[NCH-1:0] = en_q;
            A_PEND:   bus_rdata[NCH-1:0] = pend_q;
            A_FIFO: begin
                for (int k = 0; k < NCH; k++) begin
                    bus_rdata[2*k+1] = fifo_full[k];
                    bus_rdata[2*k]   = fifo_empty[k];
                end
            end
            A_FCTRL:  bus_rdata[HSRC_W-1:0] = hash_src;
            default:  ;
        endcase
        for (int k = 0; k < NCH; k++)
            bus_rdata = bus_rdata | ch_rd[k];
        if (bus_addr == PK_CTRL)
            bus_rdata[2:1] = pk_mode_q;
    end

    p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend_q & en_q) != '0));
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_start));
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(!rst_n) |-> (chan_start == '0 && pend_q == '0 && en_q == '0));
endmodule

// File: tb/dfic_top_tb.sv
module dfic_top_tb;
    localparam int NCH = 4;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NCH-1:0]    chan_done = '0, fifo_full = '0, fifo_empty = '0;
    logic [NCH-1:0]    chan_start, chan_flush, chan_swap;
    logic [NCH*DW-1:0] chan_addr, chan_len;
    logic              pk_transmit, pk_descend, irq;
    logic [1:0]        hash_src;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;   // 250 MHz

    dfic_top #(.NCH(NCH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_done(chan_done),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .chan_start(chan_start),
        .chan_addr(chan_addr), .chan_len(chan_len), .chan_flush(chan_flush),
        .chan_swap(chan_swap), .pk_transmit(pk_transmit), .pk_descend(pk_descend),
        .hash_src(hash_src), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write: drive at a falling edge, captured at the next rising edge,
    // returns at the falling edge after that capture.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // {write address, write data, read address, expected readback}
    localparam int NV = 10;
    localparam logic [79:0] VEC [NV] = '{
        {8'h04, 32'h0000000F, 8'h04, 32'h0000000F},  // R1 set all
        {8'h08, 32'h00000005, 8'h04, 32'h0000000A},  // R1 clear bits 2,0
        {8'h04, 32'h00000000, 8'h04, 32'h0000000A},  // R1 zeros no effect
        {8'h20, 32'hDEADBEEF, 8'h20, 32'hDEADBEEF},  // R7 block-rx address
        {8'h54, 32'h00000100, 8'h54, 32'h00000100},  // R7 public-key length
        {8'h38, 32'h00000002, 8'h38, 32'h00000002},  // R9 block-tx swap
        {8'h58, 32'h0000000E, 8'h58, 32'h0000000E},  // R9 pk transmit/descend/swap
        {8'h14, 32'h00000002, 8'h14, 32'h00000002},  // R6 hash source = cipher output
        {8'h48, 32'h00000003, 8'h48, 32'h00000002},  // R9 flush self-clears
        {8'h28, 32'h000000FD, 8'h28, 32'h00000000}   // R9 undefined bits read 0
    };

    logic [31:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(8'h04, v); check("R10 enable after reset", v, 0);
        rd(8'h0C, v); check("R10 pending after reset", v, 0);
        rd(8'h00, v); check("R10 status after reset", v, 0);
        rd(8'h14, v); check("R10 hash source after reset", v, 0);
        check("R10 irq after reset", {31'd0, irq}, 0);
        check("R10 addresses after reset", {31'd0, chan_addr != '0}, 0);

        // Table walk: write, wait one cycle, read back
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][79:72], VEC[k][71:40]);
            @(negedge clk);
            rd(VEC[k][39:32], v);
            check($sformatf("table[%0d] R1/R6/R7/R9", k), v, VEC[k][31:0]);
        end
        check("R9 swap outputs", {28'd0, chan_swap}, 32'h7);
        check("R9 pk mode outputs", {30'd0, pk_descend, pk_transmit}, 32'h3);
        check("R6 hash source output", {30'd0, hash_src}, 32'h2);

        // R2/R4: done pulses on block-tx and hash-rx, enable is 0xA
        @(negedge clk); chan_done = 4'b0110;
        @(negedge clk); chan_done = 4'b0000;
        rd(8'h0C, v); check("R2 pending set by done", v, 32'h6);
        rd(8'h00, v); check("R4 status masked", v, 32'h2);
        check("R4 irq high", {31'd0, irq}, 1);
        wr(8'h0C, 32'h2);
        rd(8'h0C, v); check("R2 write-one clears only bit 1", v, 32'h4);
        check("R4 irq low when masked only", {31'd0, irq}, 0);
        wr(8'h0C, 32'h4);
        rd(8'h0C, v); check("R2 pending cleared", v, 0);

        // R3: done on block-rx collides with its clear
        @(negedge clk); chan_done = 4'b1000;
        @(negedge clk); chan_done = 4'b0000;
        @(negedge clk);
        bus_addr = 8'h0C; bus_we = 1'b1; bus_wdata = 32'h8; chan_done = 4'b1000;
        @(negedge clk);
        bus_we = 1'b0; chan_done = 4'b0000;
        rd(8'h0C, v); check("R3 done beats clear", v, 32'h8);
        check("R3 irq still raised", {31'd0, irq}, 1);

        // R5 FIFO level layout
        fifo_full = 4'b1001; fifo_empty = 4'b0110;
        rd(8'h10, v); check("R5 fifo status", v, 32'h96);

        // R8 start pulse on block-tx
        wr(8'h30, 32'h00001000);
        wr(8'h34, 32'h00000040);
        check("R8 start pulse", {28'd0, chan_start}, 32'h4);
        check("R8 address at start", chan_addr[2*DW +: DW], 32'h1000);
        check("R8 length at start", chan_len[2*DW +: DW], 32'h40);
        @(negedge clk);
        check("R8 start one cycle", {28'd0, chan_start}, 0);

        // R9 flush pulse on block-rx
        wr(8'h28, 32'h1);
        check("R9 flush pulse", {28'd0, chan_flush}, 32'h8);
        @(negedge clk);
        check("R9 flush self-clear", {28'd0, chan_flush}, 0);

        // R10 reset mid-run, with a length write held against it
        @(negedge clk);
        rst_n = 1'b0; bus_addr = 8'h44; bus_we = 1'b1; bus_wdata = 32'h10;
        @(negedge clk);
        check("R10 no start during reset", {28'd0, chan_start}, 0);
        bus_we = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd(8'h0C, v); check("R10 pending cleared", v, 0);
        rd(8'h58, v); check("R10 pk control cleared", v, 0);
        rd(8'h20, v); check("R10 address cleared", v, 0);
        check("R10 irq cleared", {31'd0, irq}, 0);

        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule